// File: doc/BRIEF.md
# Command Mailbox with In-Place Completion Status

This block is the device side of a host-to-device command channel. The host fills a small register file with a subsystem code and up to eight parameter words, then writes a command word into the mailbox. The block latches the command code, decides whether the code belongs to the supported set, and either hands it to an internal executor or rejects it at once. Completion is reported in place: the upper byte of the mailbox word changes from the pending value to a fixed status pattern, while the lower byte keeps the command code. The host polls that byte.

The executor is modelled by a narrow port. The block raises a one-cycle request carrying the command code, subsystem, channel (parameter 0) and gain (parameter 1). The executor answers with a done pulse, an error bit and a result word. A successful single-read command stores the result in parameter 2. Every completion, whether success, error or rejection, sets a command-done flag that drives an interrupt line. The host clears the flag with a write-one-to-clear. All pins are plain control and status signals. The host interface has no back-pressure: the only flow control is the busy state, during which further mailbox writes are dropped.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the mailbox word, all parameter words, the subsystem word and the flag register read 0, and busy, irq and exe_req are low.
- R2: A mailbox write while idle stores wdata[7:0] in mailbox bits 7:0 and forces bits 15:8 to 0x00. Bits 15:8 stay 0x00 and busy stays high from the next cycle until the command completes.
- R3: A supported code (0 to 8, 16 to 19, 32 to 38, 48) raises exe_req for exactly one cycle, in the cycle after the mailbox write. During that cycle exe_cmd shows the code, exe_sub the subsystem word, exe_chan parameter 0 and exe_gain parameter 1.
- R4: An exe_done pulse while waiting completes the command on that clock edge. Mailbox bits 15:8 become 0x55 when exe_err is 0 and 0xAA when it is 1.
- R5: Any other code completes one cycle after the mailbox write with status 0xFF, and no exe_req is raised.
- R6: A single-read command (code 5) that succeeds writes exe_result into parameter 2 on the completion edge. Other commands and failed commands leave parameter 2 unchanged.
- R7: A mailbox write while busy is ignored: the code, the status byte and the executor request are unaffected.
- R8: Every completion sets bit 7 of the flag register and drives irq high. A host write to the flag register with wdata[7]=1 clears the bit. A completion on the same edge wins over the clear.
- R9: exe_done is ignored while no command is waiting. The mailbox and the flag do not change.
- R10: Register map (read and write): parameters at addresses 0 to 7, subsystem at 8, mailbox at 9, flag at 10. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 4 | Host write address |
| host_wdata | input | 16 | Host write data |
| host_raddr | input | 4 | Host read address |
| host_rdata | output | 16 | Host read data, combinational from host_raddr |
| busy | output | 1 | A command is in flight |
| irq | output | 1 | Command-done flag |
| exe_req | output | 1 | One-cycle executor request |
| exe_cmd | output | 8 | Command code to executor |
| exe_sub | output | 16 | Subsystem word to executor |
| exe_chan | output | 16 | Channel (parameter 0) |
| exe_gain | output | 16 | Gain (parameter 1) |
| exe_done | input | 1 | Executor completion pulse |
| exe_err | input | 1 | Executor error, valid with exe_done |
| exe_result | input | 16 | Executor result, valid with exe_done |

## Verification
The bench builds the block with the default eight parameter words and 16-bit data. This gives a 4-bit address space in which addresses 11 to 15 are unmapped, so the zero readback is exercised. Parameter 2 sits inside the array, so the loading of the result can be told apart from host writes to its neighbours. The sequence covers codes on both sides of every edge of the supported set, success and error answers, writes during busy, a stray done pulse, and a flag clear that lands on the completion edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT, PH_REJECT} mbx_phase_e;

  localparam logic [7:0] ST_PENDING   = 8'h00;
  localparam logic [7:0] ST_OK        = 8'h55;
  localparam logic [7:0] ST_FAIL      = 8'hAA;
  localparam logic [7:0] ST_UNSUP     = 8'hFF;
  localparam logic [7:0] CMD_RD_ONE   = 8'd5;
  localparam int         DONE_BIT     = 7;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c <= 8'd8) || (c >= 8'd16 && c <= 8'd19) ||
           (c >= 8'd32 && c <= 8'd38) || (c == 8'd48);
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode (
  input  logic [7:0] code,
  output logic       known
);
  assign known = mbx_pkg::cmd_known(code);
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
  parameter int DATA_W  = 16,
  parameter int NPARAM  = 8,
  parameter int RES_IDX = 2,
  localparam int IDX_W  = $clog2(NPARAM)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          par_we,
  input  logic [IDX_W-1:0]              par_idx,
  input  logic                          sub_we,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          ld_en,
  input  logic [DATA_W-1:0]             ld_data,
  output logic [NPARAM-1:0][DATA_W-1:0] par_q,
  output logic [DATA_W-1:0]             sub_q
);
  for (genvar i = 0; i < NPARAM; i++) begin : g_par
    if (i == RES_IDX) begin : g_res
      always_ff @(posedge clk) begin
        if (!rst_n)                                  par_q[i] <= '0;
        else if (ld_en)                              par_q[i] <= ld_data;
        else if (par_we && par_idx == IDX_W'(i))     par_q[i] <= wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)                                  par_q[i] <= '0;
        else if (par_we && par_idx == IDX_W'(i))     par_q[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      sub_q <= '0;
    else if (sub_we) sub_q <= wdata;
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mbx_wr,
  input  logic [7:0]  wr_code,
  input  logic        wr_known,
  input  logic        flag_clr,
  input  logic        exe_done,
  input  logic        exe_err,
  output logic [15:0] mbx_word,
  output logic        busy,
  output logic        exe_req,
  output logic        done_flag,
  output logic        load_result
);
  mbx_phase_e ph_q;
  logic [7:0] code_q, stat_q;
  logic       finish;

  assign finish      = (ph_q == PH_WAIT && exe_done) || (ph_q == PH_REJECT);
  assign busy        = (ph_q != PH_IDLE);
  assign exe_req     = (ph_q == PH_ISSUE);
  assign load_result = (ph_q == PH_WAIT) && exe_done && !exe_err && (code_q == CMD_RD_ONE);
  assign mbx_word    = {stat_q, code_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      code_q    <= '0;
      stat_q    <= ST_PENDING;
      done_flag <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (mbx_wr) begin
          code_q <= wr_code;
          stat_q <= ST_PENDING;
          ph_q   <= wr_known ? PH_ISSUE : PH_REJECT;
        end
        PH_ISSUE: ph_q <= PH_WAIT;
        PH_WAIT: if (exe_done) begin
          stat_q <= exe_err ? ST_FAIL : ST_OK;
          ph_q   <= PH_IDLE;
        end
        default: begin
          stat_q <= ST_UNSUP;
          ph_q   <= PH_IDLE;
        end
      endcase
      if (finish)        done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int NPARAM = 8,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(NPARAM + 3),
  localparam int IDX_W  = $clog2(NPARAM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [DATA_W-1:0] host_rdata,
  output logic              busy,
  output logic              irq,
  output logic              exe_req,
  output logic [7:0]        exe_cmd,
  output logic [DATA_W-1:0] exe_sub,
  output logic [DATA_W-1:0] exe_chan,
  output logic [DATA_W-1:0] exe_gain,
  input  logic              exe_done,
  input  logic              exe_err,
  input  logic [DATA_W-1:0] exe_result
);
  localparam logic [ADDR_W-1:0] A_SUB  = ADDR_W'(NPARAM);
  localparam logic [ADDR_W-1:0] A_MBX  = ADDR_W'(NPARAM + 1);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NPARAM + 2);
  localparam int CHAN_IDX = 0;
  localparam int GAIN_IDX = 1;
  localparam int RES_IDX  = 2;

  logic [NPARAM-1:0][DATA_W-1:0] par_q;
  logic [DATA_W-1:0] sub_q;
  logic [15:0]       mbx_word;
  logic              known, done_flag, load_result;
  logic              par_we, mbx_wr, flag_clr;

  assign par_we   = host_we && (host_waddr < ADDR_W'(NPARAM));
  assign mbx_wr   = host_we && (host_waddr == A_MBX);
  assign flag_clr = host_we && (host_waddr == A_FLAG) && host_wdata[mbx_pkg::DONE_BIT];

  mbx_decode u_dec (.code(host_wdata[7:0]), .known(known));

  mbx_regfile #(.DATA_W(DATA_W), .NPARAM(NPARAM), .RES_IDX(RES_IDX)) u_rf (
    .clk, .rst_n, .par_we, .par_idx(host_waddr[IDX_W-1:0]),
    .sub_we(host_we && host_waddr == A_SUB), .wdata(host_wdata),
    .ld_en(load_result), .ld_data(exe_result), .par_q, .sub_q
  );

  mbx_ctrl u_ctl (
    .clk, .rst_n, .mbx_wr, .wr_code(host_wdata[7:0]), .wr_known(known),
    .flag_clr, .exe_done, .exe_err, .mbx_word, .busy, .exe_req,
    .done_flag, .load_result
  );

  assign irq      = done_flag;
  assign exe_cmd  = mbx_word[7:0];
  assign exe_sub  = sub_q;
  assign exe_chan = par_q[CHAN_IDX];
  assign exe_gain = par_q[GAIN_IDX];

  always_comb begin
    host_rdata = '0;
    if (host_raddr < ADDR_W'(NPARAM)) host_rdata = par_q[host_raddr[IDX_W-1:0]];
    else if (host_raddr == A_SUB)     host_rdata = sub_q;
    else if (host_raddr == A_MBX)     host_rdata = DATA_W'(mbx_word);
    else if (host_raddr == A_FLAG)    host_rdata = DATA_W'({done_flag, 7'b0});
  end
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] MBX_ADDR = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_waddr,
  input logic              busy,
  input logic              exe_req,
  input logic              irq,
  input logic [15:0]       mbx
);
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exe_req |=> !exe_req);
  p_req_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exe_req |-> busy && !$past(busy));
  p_pending_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mbx[15:8] == 8'h00);
  p_final_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mbx[15:8] == 8'h55 || mbx[15:8] == 8'hAA || mbx[15:8] == 8'hFF));
  p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
  p_busy_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && host_waddr == MBX_ADDR) |=> $stable(mbx[7:0]));
endmodule

bind cmd_mailbox cmd_mailbox_chk #(.ADDR_W(ADDR_W), .MBX_ADDR(A_MBX)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
  .busy(busy), .exe_req(exe_req), .irq(irq), .mbx(mbx_word)
);

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;
  localparam int A_SUB = 8, A_MBX = 9, A_FLAG = 10;

  logic clk = 0, rst_n = 0;
  logic host_we = 0;
  logic [3:0] host_waddr = 0, host_raddr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic busy, irq, exe_req;
  logic [7:0] exe_cmd;
  logic [15:0] exe_sub, exe_chan, exe_gain;
  logic exe_done = 0, exe_err = 0;
  logic [15:0] exe_result = 0;

  int tests = 0, fails = 0;
  bit live = 0;

  cmd_mailbox uut (.*);

  always #2 clk = ~clk;

  // reference model state
  int m_ph = 0;
  logic [15:0] m_mbx = 0, m_sub = 0;
  logic [15:0] m_par [8];
  bit m_flag = 0;

  function automatic bit supp(input logic [7:0] c);
    case (c) inside
      [8'd0:8'd8], [8'd16:8'd19], [8'd32:8'd38], 8'd48: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_mbx = 0; m_sub = 0; m_flag = 0;
      foreach (m_par[i]) m_par[i] = 0;
    end else begin
      automatic bit fin = 0;
      if (host_we && host_waddr < 8) m_par[host_waddr] = host_wdata;
      if (host_we && host_waddr == A_SUB) m_sub = host_wdata;
      case (m_ph)
        0: if (host_we && host_waddr == A_MBX) begin
             m_mbx = {8'h00, host_wdata[7:0]};
             m_ph = supp(host_wdata[7:0]) ? 1 : 3;
           end
        1: m_ph = 2;
        2: if (exe_done) begin
             m_mbx[15:8] = exe_err ? 8'hAA : 8'h55;
             if (!exe_err && m_mbx[7:0] == 8'd5) m_par[2] = exe_result;
             fin = 1; m_ph = 0;
           end
        default: begin m_mbx[15:8] = 8'hFF; fin = 1; m_ph = 0; end
      endcase
      if (host_we && host_waddr == A_FLAG && host_wdata[7]) m_flag = 0;
      if (fin) m_flag = 1;
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (live) begin
      automatic logic [15:0] exp_rd;
      chk("R2 busy", busy, m_ph != 0);
      chk("R3 exe_req", exe_req, m_ph == 1);
      chk("R8 irq", irq, m_flag);
      if (m_ph == 1) begin
        chk("R3 exe_cmd", exe_cmd, m_mbx[7:0]);
        chk("R3 exe_sub", exe_sub, m_sub);
        chk("R3 exe_chan", exe_chan, m_par[0]);
        chk("R3 exe_gain", exe_gain, m_par[1]);
      end
      if (host_raddr < 8)           exp_rd = m_par[host_raddr];
      else if (host_raddr == A_SUB) exp_rd = m_sub;
      else if (host_raddr == A_MBX) exp_rd = m_mbx;
      else if (host_raddr == A_FLAG) exp_rd = {8'h00, m_flag, 7'b0};
      else                          exp_rd = 0;
      chk("R10 rdata", host_rdata, exp_rd);
    end
  end

  task automatic wr(input int a, input logic [15:0] d);
    host_we = 1; host_waddr = 4'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    host_raddr = 4'(a); #1; d = host_rdata;
  endtask

  task automatic done_pulse(input bit e, input logic [15:0] r);
    exe_done = 1; exe_err = e; exe_result = r;
    @(negedge clk);
    exe_done = 0; exe_err = 0;
  endtask

  task automatic run(input logic [7:0] c, input int lat, input bit e, input logic [15:0] r,
                     input logic [7:0] exp_st);
    logic [15:0] v;
    wr(A_MBX, {8'h5A, c});
    rd(A_MBX, v);
    chk("R2 pending byte", v, {8'h00, c});
    chk(supp(c) ? "R3 request raised" : "R5 no request", exe_req, supp(c));
    if (supp(c)) begin
      repeat (lat) @(negedge clk);
      done_pulse(e, r);
    end else @(negedge clk);
    rd(A_MBX, v);
    chk(exp_st == 8'hFF ? "R5 unsupported status" : "R4 status", v, {exp_st, c});
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1; live = 1;
    rd(A_MBX, v); chk("R1 mailbox reset", v, 0);
    rd(2, v);     chk("R1 param reset", v, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 irq reset", irq, 0);

    wr(0, 16'h0003); wr(1, 16'h0002); wr(2, 16'h1111); wr(A_SUB, 16'h0000);
    run(8'd5, 2, 0, 16'hBEEF, 8'h55);
    rd(2, v); chk("R6 result in param 2", v, 16'hBEEF);
    chk("R8 irq after completion", irq, 1);
    wr(A_FLAG, 16'h0080);
    chk("R8 flag cleared", irq, 0);

    run(8'd5, 1, 1, 16'h2222, 8'hAA);
    rd(2, v); chk("R6 failed read keeps param 2", v, 16'hBEEF);
    wr(A_SUB, 16'h0004);
    run(8'd37, 3, 0, 16'h3333, 8'h55);
    rd(2, v); chk("R6 other command keeps param 2", v, 16'hBEEF);

    run(8'd0, 1, 0, 0, 8'h55);
    run(8'd8, 1, 0, 0, 8'h55);
    run(8'd9, 0, 0, 0, 8'hFF);
    run(8'd15, 0, 0, 0, 8'hFF);
    run(8'd16, 1, 0, 0, 8'h55);
    run(8'd19, 1, 1, 0, 8'hAA);
    run(8'd20, 0, 0, 0, 8'hFF);
    run(8'd31, 0, 0, 0, 8'hFF);
    run(8'd32, 1, 0, 0, 8'h55);
    run(8'd38, 1, 0, 0, 8'h55);
    run(8'd39, 0, 0, 0, 8'hFF);
    run(8'd48, 2, 0, 0, 8'h55);
    run(8'd49, 0, 0, 0, 8'hFF);
    run(8'd255, 0, 0, 0, 8'hFF);

    // R7: mailbox write while busy is dropped
    wr(A_MBX, 16'h0003);
    wr(A_MBX, 16'h0007);
    wr(A_MBX, 16'h0063);
    rd(A_MBX, v); chk("R7 busy write ignored", v, 16'h0003);
    done_pulse(0, 0);
    rd(A_MBX, v); chk("R7 original command completes", v, 16'h5503);

    // R9: stray done while idle
    wr(A_FLAG, 16'h0080);
    done_pulse(1, 16'h9999);
    rd(A_MBX, v); chk("R9 stray done keeps mailbox", v, 16'h5503);
    chk("R9 stray done keeps flag", irq, 0);
    rd(2, v); chk("R9 stray done keeps param 2", v, 16'hBEEF);

    // R8: completion beats a clear on the same edge
    wr(A_MBX, 16'h0002);
    @(negedge clk);
    host_we = 1; host_waddr = 4'(A_FLAG); host_wdata = 16'h0080;
    done_pulse(0, 0);
    host_we = 0;
    chk("R8 set wins over clear", irq, 1);
    rd(A_FLAG, v); chk("R8 flag bit 7", v, 16'h0080);

    // R10: unmapped addresses read zero
    for (int a = 11; a < 16; a++) begin
      rd(a, v); chk("R10 unmapped reads zero", v, 0);
    end
    wr(7, 16'hA5A5); rd(7, v); chk("R10 param 7 map", v, 16'hA5A5);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule